// File: doc/BRIEF.md
# Flash block write-protection checker

This block rules on every program, page-erase and mass-erase request made to an on-chip flash array. It keeps a shadow copy of an 8-bit guard byte that is itself stored in flash. From that byte it decodes a protected start address on a 128-byte boundary. The protected region runs from that start address up to and including the top of the 16-bit address space. Each request is compared against this region, and a registered grant or deny verdict comes back one clock later.

A guard byte of all ones means nothing is protected. Any other value protects its region and also blocks mass erase. A high-voltage bypass input, raised while the interrupt pin sits at programming voltage, overrides all protection. The guard byte lives at address $FF7E. The shadow copy tracks granted operations that touch that location, so the decoded region stays in step with the array. It can also be loaded directly with a one-cycle strobe, for example when the byte is first fetched from flash after power-up.

Top module: `flash_guard`

## Requirements
- R1: After reset, rsp_valid and rsp_grant are 0, the shadow guard byte is $FF, prot_active is 0 and prot_start reads $FF80.
- R2: prot_start is always {1, guard byte, 7'b0} and prot_active is 1 exactly when the guard byte is not $FF. A key_load pulse replaces the guard byte with key_value, and the change is visible in the next cycle.
- R3: The operation code is 2'b00 program, 2'b01 page erase, 2'b10 mass erase and 2'b11 reserved. rsp_valid is high exactly one cycle after req_valid. rsp_grant is never high without rsp_valid. A reserved code is always denied, even under bypass.
- R4: With protection active and no bypass, a program is denied when req_addr >= prot_start and granted otherwise. This includes every address below $8000.
- R5: With protection active and no bypass, a page erase is judged on its page base (req_addr with bits [6:0] cleared). It is denied when that base >= prot_start.
- R6: With protection active and no bypass, mass erase is always denied.
- R7: With the guard byte at $FF, every program, page erase and mass erase is granted at any address.
- R8: With hv_bypass high, every non-reserved operation is granted whatever the guard byte.
- R9: A granted program to $FF7E sets the guard byte to (guard byte AND key_value), because programming only clears bits. A denied operation never changes the guard byte.
- R10: A granted page erase whose page base is $FF00 sets the guard byte to $FF. So does any granted mass erase. An erase of any other page leaves the guard byte alone.
- R11: A request is judged against the guard byte held before its cycle. When key_load coincides with a request, the loaded value wins over the request's own effect on the guard byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | 16 | Target byte address |
| key_load | input | 1 | One-cycle strobe that loads the shadow guard byte |
| key_value | input | 8 | Value to load, or program data aimed at $FF7E |
| hv_bypass | input | 1 | High-voltage condition present; overrides protection |
| rsp_valid | output | 1 | Verdict valid, one cycle after req_valid |
| rsp_grant | output | 1 | 1 = request allowed, 0 = denied |
| prot_start | output | 16 | Decoded first protected address |
| prot_active | output | 1 | Some region is protected |

## Verification
A wrong shadow guard byte shows at once on prot_start and prot_active, in the cycle after the load or operation that corrupted it. It also skews every later verdict near the region boundary. A faulty comparison or page-base rule shows only at addresses on either side of a 128-byte boundary. The bench therefore sweeps page starts and page ends across the whole upper half of memory, for many guard values. Update faults show as a prot_start mismatch one cycle after a granted program or erase of the $FF00 page.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int FG_ADDR_W = 16;
    localparam int FG_KEY_W  = 8;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_PAGE = 2'b01,
        OP_MASS = 2'b10,
        OP_RSVD = 2'b11
    } fg_op_e;

endpackage

// File: rtl/flash_guard_decode.sv
module flash_guard_decode #(
    parameter int ADDR_W = flash_guard_pkg::FG_ADDR_W,
    parameter int KEY_W  = flash_guard_pkg::FG_KEY_W
) (
    input  logic [KEY_W-1:0]  key,
    output logic [ADDR_W-1:0] start,
    output logic              active
);
    localparam int OFS_W = ADDR_W - 1 - KEY_W;

    // Top bit forced high, low page-offset bits forced low.
    assign start  = {1'b1, key, {OFS_W{1'b0}}};
    assign active = (key != {KEY_W{1'b1}});

endmodule

// File: rtl/flash_guard_judge.sv
module flash_guard_judge
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = FG_ADDR_W,
    parameter int KEY_W  = FG_KEY_W
) (
    input  fg_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] start,
    input  logic              active,
    input  logic              hv,
    output logic [ADDR_W-1:0] page_base,
    output logic              grant
);
    localparam int OFS_W = ADDR_W - 1 - KEY_W;

    logic blocked;

    assign page_base = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    always_comb begin
        case (op)
            OP_PROG: blocked = (addr >= start);
            // start is page aligned, so a page overlaps the region iff its base does
            OP_PAGE: blocked = (page_base >= start);
            default: blocked = 1'b1;
        endcase

        if (op == OP_RSVD) begin
            grant = 1'b0;
        end else if (hv || !active) begin
            grant = 1'b1;
        end else begin
            grant = !blocked;
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int                 ADDR_W   = FG_ADDR_W,
    parameter int                 KEY_W    = FG_KEY_W,
    parameter logic [ADDR_W-1:0]  KEY_ADDR = 16'hFF7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              key_load,
    input  logic [KEY_W-1:0]  key_value,
    input  logic              hv_bypass,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [ADDR_W-1:0] prot_start,
    output logic              prot_active
);
    localparam int                OFS_W    = ADDR_W - 1 - KEY_W;
    localparam logic [ADDR_W-1:0] KEY_PAGE = {KEY_ADDR[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    localparam logic [KEY_W-1:0]  KEY_OPEN = {KEY_W{1'b1}};

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             vld;
        logic             grant;
    } fg_state_t;

    fg_state_t         state_d, state_q;
    fg_op_e            op;
    logic              grant_c;
    logic [ADDR_W-1:0] page_base;

    assign op = fg_op_e'(req_op);

    flash_guard_decode #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) decode_i (
        .key    (state_q.key),
        .start  (prot_start),
        .active (prot_active)
    );

    flash_guard_judge #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) judge_i (
        .op        (op),
        .addr      (req_addr),
        .start     (prot_start),
        .active    (prot_active),
        .hv        (hv_bypass),
        .page_base (page_base),
        .grant     (grant_c)
    );

    always_comb begin
        state_d       = state_q;
        state_d.vld   = req_valid;
        state_d.grant = req_valid && grant_c;

        if (key_load) begin
            state_d.key = key_value;
        end else if (req_valid && grant_c) begin
            case (op)
                OP_PROG: if (req_addr == KEY_ADDR) state_d.key = state_q.key & key_value;
                OP_PAGE: if (page_base == KEY_PAGE) state_d.key = KEY_OPEN;
                OP_MASS: state_d.key = KEY_OPEN;
                default: state_d.key = state_q.key;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{key: KEY_OPEN, vld: 1'b0, grant: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.vld;
    assign rsp_grant = state_q.grant;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int ADDR_W = 16,
    parameter int KEY_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              key_load,
    input logic [KEY_W-1:0]  key_value,
    input logic              hv_bypass,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [ADDR_W-1:0] prot_start,
    input logic              prot_active
);
    localparam int OFS_W = ADDR_W - 1 - KEY_W;

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_valid);
    // R3
    rsvd_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |=> !rsp_grant);
    // R2
    load_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> (prot_start == {1'b1, $past(key_value), {OFS_W{1'b0}}}));
    // R4
    prog_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00 && !hv_bypass && prot_active && req_addr >= prot_start)
        |=> !rsp_grant);
    // R6
    mass_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && !hv_bypass && prot_active) |=> !rsp_grant);
    // R7
    open_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b11 && !prot_active) |=> rsp_grant);
    // R8
    bypass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b11 && hv_bypass) |=> rsp_grant);

endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .key_load    (key_load),
    .key_value   (key_value),
    .hv_bypass   (hv_bypass),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .prot_start  (prot_start),
    .prot_active (prot_active)
);

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [15:0] req_addr = 16'h0000;
    logic        key_load = 1'b0;
    logic [7:0]  key_value = 8'hFF;
    logic        hv_bypass = 1'b0;
    logic        rsp_valid, rsp_grant, prot_active;
    logic [15:0] prot_start;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [7:0] mkey = 8'hFF;

    always #4 clk = ~clk;

    flash_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .key_load(key_load), .key_value(key_value),
        .hv_bypass(hv_bypass), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .prot_start(prot_start), .prot_active(prot_active)
    );

    task automatic check_val(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_grant(logic [1:0] op, logic [15:0] a, logic hv, logic [7:0] k);
        logic [15:0] st;
        st = {1'b1, k, 7'h00};
        if (op == 2'b11) return 1'b0;
        if (hv || k == 8'hFF) return 1'b1;
        case (op)
            2'b00:   return a < st;
            2'b01:   return {a[15:7], 7'h00} < st;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] op, logic hv, logic [7:0] k);
        if (op == 2'b11) return "R3";
        if (hv) return "R8";
        if (k == 8'hFF) return "R7";
        case (op)
            2'b00:   return "R4";
            2'b01:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_key(string tag);
        check_val(tag, "prot_start", prot_start, {1'b1, mkey, 7'h00});
        check_val(tag, "prot_active", prot_active, mkey != 8'hFF);
    endtask

    // Drive one request (optionally with a key load) and check the verdict a cycle later.
    task automatic apply(logic [1:0] op, logic [15:0] a, logic hv, logic ld,
                         logic [7:0] data, string tag);
        logic g;
        g = exp_grant(op, a, hv, mkey);
        if (tag == "") tag = tag_of(op, hv, mkey);
        req_valid = 1'b1; req_op = op; req_addr = a; hv_bypass = hv;
        key_load = ld; key_value = data;
        @(negedge clk);
        check_val(tag, "rsp_valid", rsp_valid, 1'b1);
        check_val(tag, "rsp_grant", rsp_grant, g);
        if (ld) mkey = data;
        else if (g) begin
            if (op == 2'b00 && a == 16'hFF7E) mkey = mkey & data;
            else if (op == 2'b01 && a[15:7] == 9'h1FE) mkey = 8'hFF;
            else if (op == 2'b10) mkey = 8'hFF;
        end
        check_key(tag);
    endtask

    task automatic idle(logic ld, logic [7:0] data, string tag);
        req_valid = 1'b0; key_load = ld; key_value = data; hv_bypass = 1'b0;
        @(negedge clk);
        check_val(tag, "rsp_valid idle", rsp_valid, 1'b0);
        check_val(tag, "rsp_grant idle", rsp_grant, 1'b0);
        if (ld) mkey = data;
        check_key(tag);
    endtask

    task automatic sweep(logic hv);
        for (int p = 16'h7F00; p <= 16'hFF80; p += 16'h80) begin
            for (int o = 0; o < 2; o++) begin
                for (int op = 0; op < 4; op++) begin
                    apply(2'(op), 16'(p + (o != 0 ? 16'h7F : 16'h00)), hv, 1'b0, 8'hFF, "");
                end
            end
        end
        for (int op = 0; op < 4; op++) apply(2'(op), 16'h1234, hv, 1'b0, 8'hFF, "");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_val("R1", "rsp_valid", rsp_valid, 1'b0);
        check_val("R1", "rsp_grant", rsp_grant, 1'b0);
        check_val("R1", "prot_start", prot_start, 16'hFF80);
        check_val("R1", "prot_active", prot_active, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        idle(1'b0, 8'hFF, "R1");

        // R2 every guard value decodes
        for (int k = 0; k < 256; k++) idle(1'b1, 8'(k), "R2");
        idle(1'b1, 8'hFF, "R2");

        // R4 R5 R6 R7 R3 verdict sweeps
        for (int k = 0; k < 256; k += 15) begin
            idle(1'b1, 8'(k), "R2");
            sweep(1'b0);
        end
        idle(1'b1, 8'hFE, "R2"); sweep(1'b0);
        idle(1'b1, 8'h80, "R2"); sweep(1'b0);
        idle(1'b1, 8'h7F, "R2"); sweep(1'b0);
        // R8 bypass sweeps
        idle(1'b1, 8'h00, "R8"); sweep(1'b1);
        idle(1'b1, 8'h3C, "R8"); sweep(1'b1);

        // R9 guard byte programming
        idle(1'b1, 8'hFF, "R9");
        apply(2'b00, 16'hFF7E, 1'b0, 1'b0, 8'hA5, "R9");
        check_val("R9", "prot_start after program", prot_start, 16'hD280);
        apply(2'b00, 16'hFF7E, 1'b0, 1'b0, 8'h00, "R9");
        check_val("R9", "denied program keeps key", prot_start, 16'hD280);
        apply(2'b00, 16'hFF7E, 1'b1, 1'b0, 8'h0F, "R9");
        check_val("R9", "bits only clear", prot_start, 16'h8280);

        // R10 erase of the guard page and mass erase
        apply(2'b01, 16'hFE80, 1'b1, 1'b0, 8'hFF, "R10");
        check_val("R10", "other page keeps key", prot_active, 1'b1);
        apply(2'b01, 16'hFF40, 1'b1, 1'b0, 8'hFF, "R10");
        check_val("R10", "guard page erase opens", prot_active, 1'b0);
        idle(1'b1, 8'h20, "R10");
        apply(2'b10, 16'h8000, 1'b0, 1'b0, 8'hFF, "R10");
        check_val("R10", "denied mass erase keeps key", prot_start, 16'h9000);
        apply(2'b10, 16'h8000, 1'b1, 1'b0, 8'hFF, "R10");
        check_val("R10", "mass erase opens", prot_start, 16'hFF80);

        // R11 load coincident with a request
        apply(2'b00, 16'h9000, 1'b0, 1'b1, 8'h00, "R11");
        check_val("R11", "judged on old key", rsp_grant, 1'b1);
        check_val("R11", "load taken", prot_start, 16'h8000);
        apply(2'b10, 16'h8000, 1'b1, 1'b1, 8'h11, "R11");
        check_val("R11", "load beats mass erase", prot_start, 16'h8880);
        idle(1'b0, 8'hFF, "R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule